// File: doc/BRIEF.md
# Auto-Reload Wakeup Interval Timer

This block produces a periodic wakeup event from a slow timekeeping clock. A down-counter is preloaded from a software-written interval value. It is decremented once per step of a selectable count source: the slow clock divided by 16, 8, 4 or 2, or a once-per-second strobe supplied from outside the block. When the counter has reached zero, the next step reloads it and sets a sticky wakeup flag. The flag, gated by an interrupt enable, forms the interrupt request.

Software changes the interval only after it has turned the timer off and has seen the write-allowed indication. That indication follows the enable with a fixed two-clock lag in both directions. The block has a 17-bit mode, used with the once-per-second source, in which bit 1 of the source select acts as bit 16 of the interval. This gives intervals of more than 18 hours. The block also detects one forbidden configuration and refuses to count while it is selected.

Top module: `wkup_timer`

## Requirements
- R1: When enabled, the flag first sets (Rf + 1) count steps after the enable is raised, and again every (Rf + 1) steps after that. Rf is the effective interval value.
- R2: The source select encodes 0 as the clock divided by 16, 1 as divided by 8, 2 as divided by 4 and 3 as divided by 2. Raising the enable before clock edge 1 puts step k at edge 1 + N*k, where N is the divider, so the flag first sets at edge 1 + N*(Rf + 1).
- R3: When bit 2 of the select is 1, the counter steps only on clock edges where the external tick strobe is 1. While the strobe stays low, the timer makes no progress.
- R4: When bit 2 of the select is 1, bit 1 of the select is bit 16 of the effective interval: select 6 with interval 0 gives Rf = 65536, and select 4 or 5 uses the interval as written.
- R5: The write-allowed output is 1 from exactly two clock edges after the enable falls, and 0 from exactly two clock edges after the enable rises.
- R6: A write strobe updates the interval only in a cycle where the enable is 0 and write-allowed is 1. Other write strobes leave the interval unchanged.
- R7: The flag holds until a clear strobe. The clear takes effect on the next edge, but a hardware set on that same edge wins.
- R8: The interrupt request equals the flag ANDed with the interrupt enable.
- R9: With select 3 and interval 0, the counter does not step and the flag stays low.
- R10: Dropping the enable leaves the flag unchanged, and re-enabling restarts a full first interval.
- R11: After reset the flag and the request are 0, write-allowed is 1, and the interval is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow timekeeping clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wk_en | input | 1 | Timer enable |
| wk_irq_en | input | 1 | Interrupt request enable |
| wk_sel | input | 3 | Count source select |
| wk_rld_wr | input | 1 | Interval write strobe |
| wk_rld_din | input | 16 | Interval value to write |
| wk_flag_clr | input | 1 | Flag clear strobe |
| tick_1hz | input | 1 | Once-per-second step strobe |
| wk_wr_ok | output | 1 | Interval write allowed |
| wk_flag | output | 1 | Sticky wakeup flag |
| wk_irq | output | 1 | Interrupt request |

## Verification
The bench measures the first flag edge and the following period for every divider and for both tick selects. An off-by-one in the reload point, or a divider tap that is wrong, therefore moves the measured edge. The 17-bit case runs a full 65537-tick interval, so a design that ignores select bit 1 fires at edge 2 instead. The write-allowed lag is probed with writes placed in the two cycles just after the enable falls: a design that accepts them, or that opens the window early, produces a shorter interval. A clear that lands on a set edge is checked for set priority, and the forbidden configuration and the stalled tick are checked for a flag that stays low.

// File: rtl/wkup_pkg.sv
package wkup_pkg;
  localparam int WK_RLD_W = 16;
  localparam int WK_SEL_W = 3;

  typedef logic [WK_RLD_W:0] wk_span_t;

  typedef enum logic [WK_SEL_W-1:0] {
    WK_DIV16   = 3'd0,
    WK_DIV8    = 3'd1,
    WK_DIV4    = 3'd2,
    WK_DIV2    = 3'd3,
    WK_TICK    = 3'd4,
    WK_TICK_B  = 3'd5,
    WK_TICK_X  = 3'd6,
    WK_TICK_XB = 3'd7
  } wk_src_e;

  // effective interval: select bit 1 extends the interval in tick modes
  function automatic wk_span_t wk_span(input logic [WK_SEL_W-1:0] sel,
                                       input logic [WK_RLD_W-1:0] rld);
    wk_span_t r;
    r = sel[2] ? {sel[1], rld} : {1'b0, rld};
    return r;
  endfunction

  function automatic logic wk_forbidden(input logic [WK_SEL_W-1:0] sel,
                                        input logic [WK_RLD_W-1:0] rld);
    return (sel == WK_DIV2) && (rld == '0);
  endfunction
endpackage

// File: rtl/wkup_handshake.sv
module wkup_handshake (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic active,
  output logic wr_ok
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      wr_ok  <= 1'b1;
    end else begin
      active <= en;
      wr_ok  <= ~active;
    end
  end

  AST_WROK_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !$past(en)) |=> wr_ok);    // R5
  AST_WROK_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |=> !wr_ok);     // R5
endmodule

// File: rtl/wkup_presc.sv
module wkup_presc #(
  parameter int DIV_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic [2:0] sel,
  input  logic       tick,
  output logic       step
);
  localparam int IW = (DIV_W > 1) ? $clog2(DIV_W) : 1;

  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] tap;
  logic [IW-1:0]    tap_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       div_cnt <= '0;
    else if (!active) div_cnt <= '0;
    else              div_cnt <= div_cnt + 1'b1;
  end

  // tap[i] strobes once every 2^(i+1) active cycles
  for (genvar i = 0; i < DIV_W; i++) begin : g_tap
    assign tap[i] = &div_cnt[i:0];
  end

  assign tap_idx = IW'(DIV_W - 1) - IW'(sel[1:0]);
  assign step    = active & (sel[2] ? tick : tap[tap_idx]);

  AST_STEP_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !step);                // R10
  AST_TICK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel[2] && !tick) |-> !step);      // R3
endmodule

// File: rtl/wkup_cnt.sv
module wkup_cnt
  import wkup_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     active,
  input  logic     step,
  input  logic     forbid,
  input  wk_span_t span,
  output logic     hit
);
  wk_span_t cnt;
  logic     adv;

  assign adv = active & step & ~forbid;
  assign hit = adv & (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!active) cnt <= span;
    else if (adv)     cnt <= (cnt == '0) ? span : cnt - 1'b1;
  end

  AST_FORBID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(active && forbid) |-> $stable(cnt));   // R9
  AST_RELOAD_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (cnt == $past(span)));                // R1
endmodule

// File: rtl/wkup_timer.sv
module wkup_timer
  import wkup_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wk_en,
  input  logic                wk_irq_en,
  input  logic [WK_SEL_W-1:0] wk_sel,
  input  logic                wk_rld_wr,
  input  logic [WK_RLD_W-1:0] wk_rld_din,
  input  logic                wk_flag_clr,
  input  logic                tick_1hz,
  output logic                wk_wr_ok,
  output logic                wk_flag,
  output logic                wk_irq
);
  logic                active;
  logic                step;
  logic                cnt_hit;
  logic                rld_take;
  logic                forbid;
  logic [WK_RLD_W-1:0] rld_q;
  wk_span_t            span;

  wkup_handshake u_hs (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (wk_en),
    .active (active),
    .wr_ok  (wk_wr_ok)
  );

  wkup_presc #(.DIV_W(DIV_W)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (active),
    .sel    (wk_sel),
    .tick   (tick_1hz),
    .step   (step)
  );

  assign span   = wk_span(wk_sel, rld_q);
  assign forbid = wk_forbidden(wk_sel, rld_q);

  wkup_cnt u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (active),
    .step   (step),
    .forbid (forbid),
    .span   (span),
    .hit    (cnt_hit)
  );

  assign rld_take = wk_rld_wr & ~wk_en & wk_wr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rld_q <= '0;
    else if (rld_take) rld_q <= wk_rld_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           wk_flag <= 1'b0;
    else if (cnt_hit)     wk_flag <= 1'b1;
    else if (wk_flag_clr) wk_flag <= 1'b0;
  end

  assign wk_irq = wk_flag & wk_irq_en;

  AST_RLD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    wk_en |=> $stable(rld_q));                       // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (wk_flag && !wk_flag_clr) |=> wk_flag);          // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_hit |=> wk_flag);                            // R7
  AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wk_flag) |-> $past(cnt_hit));              // R1
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !wk_flag |-> !wk_irq);                           // R8
endmodule

// File: tb/wkup_timer_tb.sv
module wkup_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wk_en = 1'b0;
  logic        wk_irq_en = 1'b0;
  logic [2:0]  wk_sel = 3'd0;
  logic        wk_rld_wr = 1'b0;
  logic [15:0] wk_rld_din = 16'd0;
  logic        wk_flag_clr = 1'b0;
  logic        tick_1hz = 1'b1;
  logic        wk_wr_ok, wk_flag, wk_irq;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  wkup_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wk_en(wk_en), .wk_irq_en(wk_irq_en),
    .wk_sel(wk_sel), .wk_rld_wr(wk_rld_wr), .wk_rld_din(wk_rld_din),
    .wk_flag_clr(wk_flag_clr), .tick_1hz(tick_1hz),
    .wk_wr_ok(wk_wr_ok), .wk_flag(wk_flag), .wk_irq(wk_irq)
  );

  // {select, interval}
  localparam logic [18:0] VEC [0:7] = '{
    {3'd0, 16'd3}, {3'd1, 16'd5}, {3'd2, 16'd2}, {3'd3, 16'd7},
    {3'd3, 16'd1}, {3'd4, 16'd4}, {3'd5, 16'd3}, {3'd2, 16'd0}
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock edge; inputs and samples both sit 1 ns after it
  task automatic step1();
    @(posedge clk);
    #1;
  endtask

  function automatic longint div_of(input logic [2:0] s);
    case (s)
      3'd0: return 16;
      3'd1: return 8;
      3'd2: return 4;
      3'd3: return 2;
      default: return 1;   // tick held high: one step per edge
    endcase
  endfunction

  function automatic longint span_of(input logic [2:0] s, input logic [15:0] r);
    return s[2] ? (longint'(r) + (s[1] ? 65536 : 0)) : longint'(r);
  endfunction

  task automatic run_to_flag(output longint n);
    n = 0;
    do begin
      step1();
      n++;
    end while (!wk_flag && n < 70000);
  endtask

  task automatic configure(input logic [2:0] s, input logic [15:0] r);
    wk_en = 1'b0;
    for (int i = 0; i < 4 && !wk_wr_ok; i++) step1();
    step1();
    wk_sel = s; wk_rld_din = r; wk_rld_wr = 1'b1;
    step1();
    wk_rld_wr = 1'b0; wk_flag_clr = 1'b1;
    step1();
    wk_flag_clr = 1'b0;
  endtask

  initial begin
    longint n, m, e;
    #5;
    // R11: reset state
    chk(wk_flag == 1'b0, "R11 flag", wk_flag, 0);
    chk(wk_irq == 1'b0, "R11 irq", wk_irq, 0);
    chk(wk_wr_ok == 1'b1, "R11 wr_ok", wk_wr_ok, 1);
    @(negedge clk); rst_n = 1'b1;
    step1();
    // R11: interval resets to 0, divide-by-16 gives edge 17
    wk_sel = 3'd0; wk_en = 1'b1;
    run_to_flag(n);
    chk(n == 17, "R11 reset interval", n, 17);

    // R1 R2 R3 R4: table walk
    foreach (VEC[k]) begin
      logic [2:0] s;
      logic [15:0] r;
      s = VEC[k][18:16];
      r = VEC[k][15:0];
      configure(s, r);
      wk_en = 1'b1;
      run_to_flag(n);
      e = 1 + div_of(s) * (span_of(s, r) + 1);
      chk(n == e, s[2] ? "R3 first flag" : "R2 first flag", n, e);
      wk_flag_clr = 1'b1;
      step1();
      wk_flag_clr = 1'b0;
      chk(wk_flag == 1'b0, "R7 clear", wk_flag, 0);
      m = 1;
      while (!wk_flag && m < 70000) begin step1(); m++; end
      e = div_of(s) * (span_of(s, r) + 1);
      chk(m == e, "R1 period", m, e);
    end

    // R8: request gating
    chk(wk_irq == 1'b0, "R8 masked", wk_irq, 0);
    wk_irq_en = 1'b1; #1;
    chk(wk_irq == 1'b1, "R8 enabled", wk_irq, 1);
    wk_irq_en = 1'b0;

    // R10: flag survives disable
    wk_en = 1'b0;
    repeat (6) step1();
    chk(wk_flag == 1'b1, "R10 flag kept", wk_flag, 1);

    // R9: forbidden configuration
    configure(3'd3, 16'd0);
    wk_en = 1'b1;
    repeat (60) step1();
    chk(wk_flag == 1'b0, "R9 no flag", wk_flag, 0);

    // R3: stalled tick, then one strobe
    configure(3'd4, 16'd0);
    tick_1hz = 1'b0; wk_en = 1'b1;
    repeat (30) step1();
    chk(wk_flag == 1'b0, "R3 tick low", wk_flag, 0);
    tick_1hz = 1'b1;
    step1();
    tick_1hz = 1'b0;
    chk(wk_flag == 1'b1, "R3 one tick", wk_flag, 1);
    tick_1hz = 1'b1;

    // R7: clear on a set edge; sets at edges 3,5,7
    configure(3'd4, 16'd1);
    wk_en = 1'b1;
    repeat (4) step1();
    wk_flag_clr = 1'b1;
    step1();                                   // edge 5
    chk(wk_flag == 1'b1, "R7 set wins", wk_flag, 1);
    step1();                                   // edge 6
    wk_flag_clr = 1'b0;
    chk(wk_flag == 1'b0, "R7 clear wins alone", wk_flag, 0);
    step1();                                   // edge 7
    chk(wk_flag == 1'b1, "R7 next set", wk_flag, 1);

    // R6 R5: write attempts outside the window
    wk_rld_din = 16'd9; wk_rld_wr = 1'b1;
    step1();                                   // enabled: ignored
    chk(wk_wr_ok == 1'b0, "R5 closed while on", wk_wr_ok, 0);
    wk_en = 1'b0;
    step1();                                   // D1
    chk(wk_wr_ok == 1'b0, "R5 one edge after off", wk_wr_ok, 0);
    step1();                                   // D2
    wk_rld_wr = 1'b0;
    chk(wk_wr_ok == 1'b1, "R5 two edges after off", wk_wr_ok, 1);
    wk_flag_clr = 1'b1; step1(); wk_flag_clr = 1'b0;
    wk_en = 1'b1;
    step1();                                   // E1
    chk(wk_wr_ok == 1'b1, "R5 one edge after on", wk_wr_ok, 1);
    step1();                                   // E2
    chk(wk_wr_ok == 1'b0, "R5 two edges after on", wk_wr_ok, 0);
    n = 2;
    while (!wk_flag && n < 100) begin step1(); n++; end
    chk(n == 3, "R6 writes ignored", n, 3);

    // R6: accepted write inside the window
    configure(3'd4, 16'd9);
    wk_en = 1'b1;
    run_to_flag(n);
    chk(n == 11, "R6 write taken", n, 11);

    // R4: 17-bit interval
    configure(3'd6, 16'd0);
    wk_en = 1'b1;
    run_to_flag(n);
    chk(n == 65538, "R4 extended interval", n, 65538);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule